// File: doc/BRIEF.md
# Track Crossing Pulse Generator

This block turns a tracking error signal and an off-track (mirror) flag into a track-count pulse train for use while the pickup head moves across tracks. Every time the chosen zero-cross signal changes level, in either direction, the block copies the mirror flag onto its count output. A downstream track counter then counts the output. Between zero-cross edges the output holds its value.

The zero-cross comes from one of three variants, and the variant sets when the flag is captured.
- The sampled variant is the sign of the tracking error, taken once per sample strobe.
- The phase-advanced variant is the sign of a first-order high-pass IIR filter run on the same samples. It is meant for single-track jumps.
- The delayed variant is the sampled sign passed through a short shift register. It lines up the capture with a late-arriving mirror flag during fast traverse. The delay has two settings, a short one and a long one.

The sample strobe is a one-cycle enable produced by a clock divider. All inputs are continuously sampled level signals and have no transfer boundaries, so no port carries a valid/ready handshake and there is no back-pressure.

Top module: `track_cross_gen`

## Requirements
- R1: While reset is asserted, and directly after it, `cout_o` is 0.
- R2: After reset is released, a divider starts from 0 and samples `te_i` only at rising clock edges number DIV, 2·DIV, 3·DIV and so on. A change to `te_i` that spans no sampling edge has no effect. The sampled zero-cross is bit TE_W-1 of the sample (1 means negative).
- R3: On a 0-to-1 transition of the selected zero-cross, `cout_o` takes the value of `mirror_i`.
- R4: On a 1-to-0 transition of the selected zero-cross, `cout_o` also takes the value of `mirror_i`.
- R5: While the selected zero-cross does not change, `cout_o` holds its value whatever `mirror_i` does.
- R6: When `src_hi_i` is 1, the sampled zero-cross is selected and `src_lo_i` is ignored.
- R7: When `src_hi_i`=0 and `src_lo_i`=0, the high-pass variant is selected. Its output is y += x − x_prev − (y >>> HPF_SHIFT) per sample, and the zero-cross is the sign of y. On a slow downward ramp of the error, this variant's crossing comes at least 16 samples before the sampled crossing.
- R8: When `src_hi_i`=0 and `src_lo_i`=1, the delayed variant is selected. It lags the sampled zero-cross by DLY_SHORT samples (2) when `dly_long_i`=0, and by DLY_LONG samples (4) when `dly_long_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| te_i | input | TE_W | Signed tracking error sample |
| mirror_i | input | 1 | Off-track flag to be captured |
| src_hi_i | input | 1 | Source select, high bit (1 selects the sampled variant) |
| src_lo_i | input | 1 | Source select, low bit (0 selects high-pass, 1 selects delayed) |
| dly_long_i | input | 1 | Delayed variant: 0 gives the short tap, 1 the long tap |
| cout_o | output | 1 | Track-count output |

## Verification
The error is stepped at a fixed divider phase, and the mirror flag is toggled between edges. This separates capture on rising and falling edges from holding when no edge occurs. A pulse that falls entirely between sampling edges must leave the output unchanged, which shows that sampling happens only on the strobe. Step latencies are measured for the sampled variant and for both delay taps. Their differences pin each tap to exactly two or four sample periods, and a run with both select bits high shows that the high bit takes priority. A slow downward ramp is run in both the sampled and high-pass modes, and the earlier crossing it produces in high-pass mode tells the filter path apart from the plain sign path.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  typedef enum logic [1:0] {
    SRC_HPF  = 2'b00,
    SRC_DLY  = 2'b01,
    SRC_SAMP = 2'b10
  } zc_src_e;

  function automatic zc_src_e decode_src(input logic hi, input logic lo);
    if (hi) return SRC_SAMP;
    else if (lo) return SRC_DLY;
    else return SRC_HPF;
  endfunction
endpackage

// File: rtl/tcg_strobe.sv
module tcg_strobe #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign stb_o = (cnt == LAST);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R2
      strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> !stb_o);
    end
  endgenerate
endmodule

// File: rtl/tcg_zc_sources.sv
module tcg_zc_sources #(
  parameter int TE_W      = 8,
  parameter int HPF_SHIFT = 4,
  parameter int DLY_SHORT = 2,
  parameter int DLY_LONG  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb_i,
  input  logic [TE_W-1:0] te_i,
  input  logic            dly_long_i,
  output logic            zc_samp_o,
  output logic            zc_hpf_o,
  output logic            zc_dly_o
);
  localparam int YW = TE_W + 4;

  logic [TE_W-1:0]     te_q;
  logic signed [YW-1:0] x_prev, y_acc, x_new, y_next;
  logic [DLY_LONG-1:0] dly_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) te_q <= '0;
    else if (stb_i) te_q <= te_i;
  end

  assign zc_samp_o = te_q[TE_W-1];

  assign x_new  = YW'($signed(te_i));
  assign y_next = y_acc + x_new - x_prev - (y_acc >>> HPF_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_prev <= '0;
      y_acc  <= '0;
    end else if (stb_i) begin
      x_prev <= x_new;
      y_acc  <= y_next;
    end
  end

  assign zc_hpf_o = y_acc[YW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) dly_sh <= '0;
    else if (stb_i) dly_sh <= {dly_sh[DLY_LONG-2:0], zc_samp_o};
  end

  assign zc_dly_o = dly_long_i ? dly_sh[DLY_LONG-1] : dly_sh[DLY_SHORT-1];

  // R2
  samp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(zc_samp_o));

  // R8
  dly_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> dly_sh[DLY_LONG-1:1] == $past(dly_sh[DLY_LONG-2:0]));

  // R7
  hpf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(zc_hpf_o));

  initial begin
    if (DLY_SHORT < 1 || DLY_LONG <= DLY_SHORT)
      $display("tcg_zc_sources: tap parameters out of order");
  end
endmodule

// File: rtl/tcg_capture.sv
module tcg_capture
  import tcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_hi_i,
  input  logic src_lo_i,
  input  logic zc_samp_i,
  input  logic zc_hpf_i,
  input  logic zc_dly_i,
  input  logic mirror_i,
  output logic cout_o
);
  zc_src_e src;
  logic    zc_sel, zc_prev;

  assign src = decode_src(src_hi_i, src_lo_i);

  always_comb begin
    unique case (src)
      SRC_SAMP: zc_sel = zc_samp_i;
      SRC_DLY:  zc_sel = zc_dly_i;
      default:  zc_sel = zc_hpf_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zc_prev <= 1'b0;
      cout_o  <= 1'b0;
    end else begin
      zc_prev <= zc_sel;
      if (zc_sel != zc_prev) cout_o <= mirror_i;
    end
  end

  // R6
  priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_hi_i |-> zc_sel == zc_samp_i);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_sel == zc_prev) |=> $stable(cout_o));

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_sel != zc_prev) |=> cout_o == $past(mirror_i));
endmodule

// File: rtl/track_cross_gen.sv
module track_cross_gen #(
  parameter int TE_W      = 8,
  parameter int DIV       = 8,
  parameter int HPF_SHIFT = 4,
  parameter int DLY_SHORT = 2,
  parameter int DLY_LONG  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TE_W-1:0] te_i,
  input  logic            mirror_i,
  input  logic            src_hi_i,
  input  logic            src_lo_i,
  input  logic            dly_long_i,
  output logic            cout_o
);
  logic stb, zc_samp, zc_hpf, zc_dly;

  tcg_strobe #(.DIV(DIV)) u_stb (
    .clk(clk), .rst_n(rst_n), .stb_o(stb)
  );

  tcg_zc_sources #(
    .TE_W(TE_W), .HPF_SHIFT(HPF_SHIFT),
    .DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)
  ) u_src (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .te_i(te_i),
    .dly_long_i(dly_long_i),
    .zc_samp_o(zc_samp), .zc_hpf_o(zc_hpf), .zc_dly_o(zc_dly)
  );

  tcg_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .src_hi_i(src_hi_i), .src_lo_i(src_lo_i),
    .zc_samp_i(zc_samp), .zc_hpf_i(zc_hpf), .zc_dly_i(zc_dly),
    .mirror_i(mirror_i), .cout_o(cout_o)
  );

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> !cout_o);
endmodule

// File: tb/track_cross_gen_test.sv
module track_cross_gen_test;
  localparam int DIV = 8;
  localparam int TE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TE_W-1:0] te = '0;
  logic mirror = 1'b0, s_hi = 1'b1, s_lo = 1'b0, dlong = 1'b0;
  logic cout;
  int   cyc = 0;
  int   errors = 0, checks = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  track_cross_gen #(.TE_W(TE_W), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .te_i(te), .mirror_i(mirror),
    .src_hi_i(s_hi), .src_lo_i(s_lo), .dly_long_i(dlong), .cout_o(cout)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic align();
    @(negedge clk);
    while (cyc % DIV != 0) @(negedge clk);
  endtask

  task automatic set_te(input int v);
    te = TE_W'(v);
  endtask

  // Step te at divider phase 0 and count cycles until cout becomes want.
  task automatic step_latency(input int v, input logic want, output int lat);
    align();
    set_te(v);
    lat = 0;
    while (cout != want && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    settle(4);
    check("R1 cout in reset", cout, 0);
    rst_n = 1'b1;
    settle(1);
    check("R1 cout after reset", cout, 0);
  endtask

  task automatic t_edges();
    int lat;
    s_hi = 1'b1; s_lo = 1'b0; mirror = 1'b0;
    set_te(20);
    settle(8 * DIV);
    mirror = 1'b1;
    settle(2);
    step_latency(-20, 1'b1, lat);
    check("R3 rising zero-cross captures 1", cout, 1);
    mirror = 1'b0;
    settle(6 * DIV);
    check("R5 mirror change without edge ignored", cout, 1);
    step_latency(20, 1'b0, lat);
    check("R4 falling zero-cross captures 0", cout, 0);
    mirror = 1'b1;
    settle(6 * DIV);
    check("R5 mirror high without edge ignored", cout, 0);
    // pulse fully between sampling edges
    align();
    set_te(-50);
    settle(DIV - 1);
    set_te(20);
    settle(6 * DIV);
    check("R2 pulse between strobes ignored", cout, 0);
  endtask

  task automatic prep_mode(input logic hi, input logic lo, input logic dl);
    s_hi = hi; s_lo = lo; dlong = dl;
    mirror = 1'b0;
    set_te(20);
    settle(40 * DIV);
    mirror = 1'b1;
    settle(2);
  endtask

  task automatic t_delay();
    int l_s, l_d2, l_d4, l_pr;
    prep_mode(1'b1, 1'b0, 1'b0);
    check("R3 cout low before sampled step", cout, 0);
    step_latency(-20, 1'b1, l_s);
    prep_mode(1'b0, 1'b1, 1'b0);
    step_latency(-20, 1'b1, l_d2);
    prep_mode(1'b0, 1'b1, 1'b1);
    step_latency(-20, 1'b1, l_d4);
    prep_mode(1'b1, 1'b1, 1'b1);
    step_latency(-20, 1'b1, l_pr);
    check("R8 short tap lag cycles", l_d2 - l_s, 2 * DIV);
    check("R8 long tap lag cycles", l_d4 - l_s, 4 * DIV);
    check("R6 hi bit overrides lo bit", l_pr, l_s);
    check("R2 sampled latency within one period", int'(l_s <= DIV + 1), 1);
  endtask

  task automatic ramp(input logic hi, output int k);
    s_hi = hi; s_lo = 1'b0; dlong = 1'b0;
    mirror = 1'b0;
    set_te(63);
    settle(120 * DIV);
    mirror = 1'b1;
    align();
    k = -1;
    for (int i = 0; i < 90; i++) begin
      set_te(63 - i);
      for (int c = 0; c < DIV; c++) begin
        @(negedge clk);
        if (cout && k < 0) k = i;
      end
    end
  endtask

  task automatic t_hpf();
    int k_s, k_h;
    ramp(1'b1, k_s);
    ramp(1'b0, k_h);
    check("R3 sampled ramp crossing index", int'(k_s >= 64 && k_s <= 65), 1);
    check("R7 high-pass crosses at least 16 samples earlier",
          int'(k_h >= 0 && k_h + 16 <= k_s), 1);
  endtask

  initial begin
    t_reset();
    t_edges();
    t_delay();
    t_hpf();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule